// File: doc/BRIEF.md
# Despread and Accumulate-Dump Decimator

This block sits behind an earlier decimation stage that delivers unsigned samples biased around a midpoint of 10, with a legal range of 0 to 20. A serial spreading code comes with each sample, one code bit per sample. The block removes the bias and applies the code bit in one signed step. A code bit of 0 keeps the centred value. A code bit of 1 negates it. This undoes the spreading of the wanted signal and spreads any interference. The despread values are summed over groups of 16 accepted samples, and one signed 9-bit result is released per group. A divided clock marks the group rate.

Samples enter through a valid/ready stream. A sample is taken on any cycle where `in_valid` and `in_ready` are both high. Results leave through a valid/ready stream. A result stays on `out_data` until `out_ready` takes it.

Back-pressure works as follows. The block does not buffer results. It lowers `in_ready` only when the next sample would close a group while the previous result is still waiting to be taken. All other samples are accepted even when the output stalls.

Top module: `despread_decimator`

## Requirements
- R1: A sample and its code bit are consumed only on a cycle with `in_valid` and `in_ready` both high. After reset, and while no result is waiting, `in_ready` is high.
- R2: Each sample x becomes a 6-bit signed value. With code bit 0 it is x-10. With code bit 1 it is 10-x. For legal inputs the value lies within -10..+10.
- R3: Each group result is the sign-extended 9-bit two's-complement sum of the despread values of 16 consecutive accepted samples. The range -160..+160 is exact.
- R4: The first sample after reset opens the first group. A group's sum is released when the first sample of the next group is accepted. On the next cycle `out_valid` is high and `out_data` holds that sum. The new group starts from that sample's own value, not from zero. No result is released before the 17th accepted sample.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` goes low only when a result is waiting and `out_ready` is low at the position that would close a group. It goes high in the same cycle that `out_ready` rises.
- R6: A result that is taken (`out_valid` and `out_ready` high) with no new group closing is gone on the next cycle, and `out_valid` goes low.
- R7: `dec_clk` is the top bit of the 4-bit position counter within the group. It is low after 0..7 accepted samples of a group and high after 8..15. It toggles once per 8 accepted samples, which gives a 50% duty cycle under a steady input.
- R8: A synchronous active-high `rst` clears the position counter, the accumulator and the output register. After reset `out_valid`, `out_data` and `dec_clk` are 0, and a partial group is discarded.
- R9: Cycles with no accepted sample have no effect. Gaps between samples change neither the sums nor `dec_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample and code bit are present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 5 | Biased unsigned sample, 0..20 |
| in_code | input | 1 | Spreading code bit for this sample (1 = negate) |
| out_valid | output | 1 | A group result is on out_data |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 9 | Signed group sum, two's complement |
| dec_clk | output | 1 | Group-rate clock, top bit of the position counter |

## Verification
Some properties are checked on every cycle:
- the despread value stays within ±10 for any legal input;
- a waiting result holds its value;
- a stalled input is always caused by a waiting result;
- a result appears only after an accepted sample;
- an idle cycle never moves `dec_clk`;
- reset clears the outputs.

Other behaviour needs the bench's scenarios. These cover the exact group sums for chosen code and sample patterns, the release of each sum on the first sample of the next group, the reload of the accumulator from that sample, the timing of `dec_clk` within the group, and the discarding of a partial group on reset.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic {
    CODE_KEEP = 1'b0,
    CODE_FLIP = 1'b1
  } code_e;
endpackage

// File: rtl/dsd_despread.sv
module dsd_despread
  import dsd_pkg::*;
#(
  parameter int SAMPLE_W = 5,
  parameter int OFFSET   = 10,
  localparam int DW      = SAMPLE_W + 1
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                code,
  output logic [DW-1:0]       value
);
  logic [DW-1:0] ext, off, opa, opb;

  // One subtractor: the operands are swapped by the code bit, so the
  // bias removal and the sign flip happen in the same step.
  always_comb begin
    ext = {1'b0, sample};
    off = DW'(OFFSET);
    if (code_e'(code) == CODE_FLIP) begin
      opa = off;
      opb = ext;
    end else begin
      opa = ext;
      opb = off;
    end
    value = opa - opb;
  end
endmodule

// File: rtl/dsd_group_counter.sv
module dsd_group_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic slot_first,
  output logic dump_slot,
  output logic dclk
);
  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (adv) begin
      cnt_q    <= cnt_q + 1'b1;
      primed_q <= 1'b1;
    end
  end

  assign slot_first = (cnt_q == '0);
  assign dump_slot  = slot_first && primed_q;
  assign dclk       = cnt_q[CNT_W-1];
endmodule

// File: rtl/dsd_accum.sv
module dsd_accum #(
  parameter int IN_W  = 6,
  parameter int ACC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  input  logic             dump,
  input  logic [IN_W-1:0]  din,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_data
);
  logic [ACC_W-1:0] acc_q, din_ext;

  assign din_ext = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (adv) begin
      if (load) acc_q <= din_ext;
      else      acc_q <= acc_q + din_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv && dump) begin
      out_valid <= 1'b1;
      out_data  <= acc_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/despread_decimator.sv
module despread_decimator #(
  parameter int SAMPLE_W = 5,
  parameter int OFFSET   = 10,
  parameter int CNT_W    = 4,
  parameter int ACC_W    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_code,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ACC_W-1:0]    out_data,
  output logic                dec_clk
);
  localparam int DW = SAMPLE_W + 1;

  logic [DW-1:0] desp_val;
  logic          slot_first, dump_slot, adv;

  dsd_despread #(.SAMPLE_W(SAMPLE_W), .OFFSET(OFFSET)) u_desp (
    .sample(in_sample), .code(in_code), .value(desp_val)
  );

  dsd_group_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv),
    .slot_first(slot_first), .dump_slot(dump_slot), .dclk(dec_clk)
  );

  assign in_ready = !(dump_slot && out_valid && !out_ready);
  assign adv      = in_valid && in_ready;

  dsd_accum #(.IN_W(DW), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .adv(adv), .load(slot_first), .dump(dump_slot),
    .din(desp_val), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/despread_decimator_sva.sv
module dsd_checker #(
  parameter int SAMPLE_W = 5,
  parameter int OFFSET   = 10,
  parameter int ACC_W    = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic [SAMPLE_W:0]   desp_val,
  input logic                out_valid,
  input logic                out_ready,
  input logic [ACC_W-1:0]    out_data,
  input logic                dec_clk
);
  p_despread_range_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (int'(in_sample) <= 2*OFFSET)) |->
      (($signed(desp_val) >= -OFFSET) && ($signed(desp_val) <= OFFSET)));

  p_result_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_cause_r5: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  p_taken_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  p_idle_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(dec_clk));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_data == '0) && !dec_clk));
endmodule

bind despread_decimator dsd_checker #(
  .SAMPLE_W(SAMPLE_W), .OFFSET(OFFSET), .ACC_W(ACC_W)
) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_sample(in_sample), .desp_val(desp_val), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .dec_clk(dec_clk)
);

// File: tb/despread_decimator_test.sv
module despread_decimator_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_sample = 5'd10;
  logic       in_code = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [8:0] out_data;
  logic       dec_clk;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  despread_decimator uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_code(in_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .dec_clk(dec_clk)
  );

  // row: start sample, stride (mod 21), 16 code bits (bit i for sample i)
  localparam logic [25:0] VEC [6] = '{
    {5'd20, 5'd0, 16'h0000},
    {5'd0,  5'd0, 16'h0000},
    {5'd20, 5'd0, 16'hFFFF},
    {5'd0,  5'd1, 16'h0000},
    {5'd3,  5'd7, 16'hA5C3},
    {5'd10, 5'd0, 16'hFFFF}
  };

  function automatic int xs(input logic [25:0] row, input int i);
    return (int'(row[25:21]) + i * int'(row[20:16])) % 21;
  endfunction

  function automatic int dv(input int x, input logic c);
    return c ? (10 - x) : (x - 10);
  endfunction

  function automatic int row_sum(input logic [25:0] row);
    int s = 0;
    for (int i = 0; i < 16; i++) s += dv(xs(row, i), row[i]);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int x, input logic c);
    in_valid  = 1'b1;
    in_sample = 5'(x);
    in_code   = c;
    @(posedge clk); #1;
    in_valid  = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic check_result(input string req, input int exp);
    check(out_valid === 1'b1, req, int'(out_valid), 1);
    check($signed(out_data) == exp, req, int'($signed(out_data)), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_prev;
    do_reset();
    // R8: reset state
    check(out_valid === 1'b0, "R8", int'(out_valid), 0);
    check(out_data === 9'd0, "R8", int'(out_data), 0);
    check(dec_clk === 1'b0, "R8", int'(dec_clk), 0);
    check(in_ready === 1'b1, "R1", int'(in_ready), 1);

    // Table walk: R2, R3, R4, R7
    exp_prev = 0;
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 16; i++) begin
        check(in_ready === 1'b1, "R1", int'(in_ready), 1);
        push(xs(VEC[r], i), VEC[r][i]);
        if (i == 0 && r > 0) check_result("R3/R4", exp_prev);
        if (i == 6) check(dec_clk === 1'b0, "R7", int'(dec_clk), 0);
        if (i == 7) check(dec_clk === 1'b1, "R7", int'(dec_clk), 1);
        if (i == 15) begin
          check(dec_clk === 1'b0, "R7", int'(dec_clk), 0);
          check(out_valid === 1'b0, "R4 no early result", int'(out_valid), 0);
        end
      end
      exp_prev = row_sum(VEC[r]);
    end
    push(10, 1'b0);
    check_result("R3/R4", exp_prev);
    @(posedge clk); #1;
    check(out_valid === 1'b0, "R6", int'(out_valid), 0);

    // R2: single-sample groups, others neutral (10)
    do_reset();
    begin
      int sx[5] = '{0, 20, 0, 13, 13};
      logic sc[5] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
      for (int k = 0; k < 5; k++) begin
        push(sx[k], sc[k]);
        if (k > 0) check_result("R2", dv(sx[k-1], sc[k-1]));
        for (int i = 1; i < 16; i++) push(10, 1'b0);
      end
      push(10, 1'b0);
      check_result("R2", dv(sx[4], sc[4]));
    end

    // R4 reload: the group-opening sample counts in the new group
    do_reset();
    for (int i = 0; i < 16; i++) push(10, 1'b0);
    push(20, 1'b0);
    check_result("R4", 0);
    for (int i = 1; i < 16; i++) push(10, 1'b0);
    push(10, 1'b0);
    check_result("R4 reload", 10);

    // R5 / R6 back-pressure
    do_reset();
    out_ready = 1'b0;
    for (int i = 0; i < 16; i++) push(20, 1'b0);
    push(0, 1'b0);
    check_result("R5", 160);
    for (int i = 1; i < 16; i++) push(20, 1'b0);
    check_result("R5 hold", 160);
    in_valid = 1'b1; in_sample = 5'd10; in_code = 1'b0;
    #1;
    check(in_ready === 1'b0, "R5 stall", int'(in_ready), 0);
    repeat (2) @(posedge clk);
    #1;
    check(in_ready === 1'b0, "R5 stall", int'(in_ready), 0);
    check_result("R5 hold", 160);
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R5 release", int'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_result("R5", 140);
    @(posedge clk); #1;
    check(out_valid === 1'b0, "R6", int'(out_valid), 0);

    // R9: idle gaps change nothing
    do_reset();
    for (int i = 0; i < 16; i++) begin
      logic d0;
      push(15, 1'b1);
      d0 = dec_clk;
      repeat (3) @(posedge clk);
      #1;
      if (i == 3 || i == 9) check(dec_clk === d0, "R9", int'(dec_clk), int'(d0));
    end
    push(10, 1'b0);
    check_result("R9", -80);

    // R8: reset mid-group drops the partial group
    do_reset();
    for (int i = 0; i < 9; i++) push(20, 1'b0);
    do_reset();
    check(dec_clk === 1'b0, "R8", int'(dec_clk), 0);
    check(out_valid === 1'b0, "R8", int'(out_valid), 0);
    push(0, 1'b1);
    for (int i = 1; i < 16; i++) push(10, 1'b0);
    check(out_valid === 1'b0, "R8", int'(out_valid), 0);
    push(10, 1'b0);
    check_result("R8", 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule